// File: doc/BRIEF.md
# Combined SPI and Deserial Master Arbiter

This block is an SPI master that carries two kinds of frame over one serial link. Command frames are words queued by the host in a transmit FIFO. Deserial frames are snapshots of a bank of parallel input signals, and the block builds and sends them by itself. When the shift engine is idle, a fixed-priority arbiter chooses the next frame and loads it into a single shift register. Each frame type drives its own active-low chip select, so an external deserializer can tell them apart.

Data shifted back in is routed by frame type. Returns from deserial frames update a registered parallel output bus. Returns from command frames go into a receive FIFO. Timing comes from a small table of attribute entries. A command word selects its entry through a field in the word. Deserial frames use the entry named by a separate select input.

The combined operation runs only in one mode setting, and only while the master enable is high.

Top module: `spi_dsi_arbiter`

## Requirements
- R1: Frames start only while `mode_sel` equals 2'b10 and `master_en` is 1. In any other setting no chip select goes low, and pushed commands stay queued in the transmit FIFO.
- R2: When the shift engine is idle and the transmit FIFO holds a command, that command is sent before any pending deserial frame.
- R3: When the transmit FIFO is empty, a deserial frame starts by itself if a request is pending. A request comes from a `dsi_trig` pulse or from `par_in` differing from the value latched at the last deserial frame start. `par_in` is latched when the frame starts.
- R4: `pcs_dsi_n` is low only during deserial frames and `pcs_spi_n` only during command frames. The two are never low together.
- R5: A command word is {select[1:0], data[15:0]}. Its select field, bits 17:16 of `tx_cmd`, picks its attribute entry. Deserial frames use the entry picked by `dsi_attr_sel`. Entry i occupies `attr_cfg[18*i+17:18*i]`, laid out as {after-delay[3:0], lead-delay[3:0], cpha, cpol, divider[3:0], size_minus_one[3:0]} from MSB to LSB.
- R6: A frame of N bits sends the low N bits of its data, MSB first, and `sck` makes exactly 2N transitions. `sck` sits at CPOL while the chip select is low, both before the first transition and after the last. A size_minus_one value below 3 gives a 4-bit frame.
- R7: With CPHA=0, `sin` is sampled on the first edge of each bit. With CPHA=1, it is sampled on the second edge. The received word is right-aligned and its unused upper bits are zero.
- R8: At the end of a deserial frame, `par_out` takes the received word. At all other times `par_out` holds its value. Words received in command frames are pushed into the receive FIFO.
- R9: If the receive FIFO is full when a command frame ends, the received word is dropped and `rx_ovf` is set. `rx_ovf` stays set until reset.
- R10: Both FIFOs keep first-in first-out order. A push into a full FIFO and a pop from an empty FIFO are ignored. `tx_full` and `rx_empty` report the occupancy of the FIFOs.
- R11: A frame in progress is never cut short. A command pushed during a deserial frame waits for that frame to finish.
- R12: The first `sck` transition comes lead-delay + divider + 2 clocks after the chip select falls. Transitions are divider + 1 clocks apart. The chip select rises after-delay + 1 clocks after the last transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode; 2'b10 selects combined operation |
| master_en | input | 1 | Master operation enable |
| attr_cfg | input | NUM_ATTR*ATTR_W | Packed attribute table |
| dsi_attr_sel | input | AS_W | Attribute entry used by deserial frames |
| tx_push | input | 1 | Push `tx_cmd` into the transmit FIFO |
| tx_cmd | input | AS_W+DATA_W | Command word: attribute select above data |
| tx_full | output | 1 | Transmit FIFO full |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_data | output | DATA_W | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO empty |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| par_in | input | DATA_W | Parallel inputs serialized by deserial frames |
| dsi_trig | input | 1 | Request a deserial frame |
| par_out | output | DATA_W | Parallel outputs from deserial returns |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| pcs_dsi_n | output | 1 | Active-low chip select for deserial frames |
| pcs_spi_n | output | 1 | Active-low chip select for command frames |

## Verification
A wrong arbiter choice shows up on the very next chip-select falling edge: the wrong select line goes low, or a command is held back behind a deserial frame. A corrupted shift or edge counter shows up within the same frame, as a wrong transition count or a wrong bit sequence on `sout`. Wrong return routing shows up two clocks after the chip select rises, either as a change on `par_out` or as an unexpected word at the head of the receive FIFO. Lead, half-period and trail spacing are measured in clocks on every frame, so an off-by-one in any counter is visible on the first frame that uses that attribute entry.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEAD, ST_SHIFT, ST_TRAIL} shift_state_t;
  localparam logic [1:0] MODE_COMBINED = 2'b10;
  localparam int MIN_BITS = 4;
endpackage

// File: rtl/spi_arb_fifo.sv
module spi_arb_fifo #(
  parameter int W = 16,
  parameter int DEPTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   count;
  logic do_wr, do_rd;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
      if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
      case ({do_wr, do_rd})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> full);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/spi_arb_shifter.sv
module spi_arb_shifter
  import spi_arb_pkg::*;
#(
  parameter int DW = 16,
  parameter int DIV_W = 4,
  parameter int DLY_W = 4,
  localparam int SZ_W = $clog2(DW),
  localparam int EW = SZ_W + 2,
  localparam int CW = (DIV_W > DLY_W) ? DIV_W : DLY_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    ld_data,
  input  logic [SZ_W-1:0]  size_m1,
  input  logic [DIV_W-1:0] div,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DLY_W-1:0] pre_dly,
  input  logic [DLY_W-1:0] post_dly,
  input  logic             sin,
  output logic             sck,
  output logic             sout,
  output logic             cs,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    rx_word
);
  shift_state_t     state;
  logic [CW-1:0]    cnt;
  logic [EW-1:0]    ecnt, last;
  logic [DW-1:0]    sh, rsh;
  logic             cpol_q, cpha_q;
  logic [DIV_W-1:0] div_q;
  logic [DLY_W-1:0] post_q;
  logic [SZ_W:0]    size_v;
  logic             sample_ev, shift_ev;

  assign size_v = (size_m1 < SZ_W'(MIN_BITS-1)) ? (SZ_W+1)'(MIN_BITS)
                                                : {1'b0, size_m1} + (SZ_W+1)'(1);
  assign sample_ev = cpha_q ? ecnt[0] : ~ecnt[0];
  assign shift_ev  = cpha_q ? (~ecnt[0] && (ecnt != '0)) : ecnt[0];
  assign sout    = sh[DW-1];
  assign rx_word = rsh;
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; sck <= 1'b0; cs <= 1'b0; done <= 1'b0;
      cnt <= '0; ecnt <= '0; last <= '0; sh <= '0; rsh <= '0;
      cpol_q <= 1'b0; cpha_q <= 1'b0; div_q <= '0; post_q <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_LEAD; cs <= 1'b1; sck <= cpol;
          cpol_q <= cpol; cpha_q <= cpha; div_q <= div; post_q <= post_dly;
          cnt  <= CW'(pre_dly);
          ecnt <= '0;
          last <= {size_v, 1'b0} - EW'(1);
          sh   <= ld_data << (DW - int'(size_v));
          rsh  <= '0;
        end
        ST_LEAD: if (cnt == '0) begin
          state <= ST_SHIFT; cnt <= CW'(div_q);
        end else cnt <= cnt - CW'(1);
        ST_SHIFT: if (cnt == '0) begin
          sck  <= ~sck;
          cnt  <= CW'(div_q);
          ecnt <= ecnt + EW'(1);
          if (sample_ev) rsh <= {rsh[DW-2:0], sin};
          if (shift_ev)  sh  <= {sh[DW-2:0], 1'b0};
          if (ecnt == last) begin
            state <= ST_TRAIL; cnt <= CW'(post_q);
          end
        end else cnt <= cnt - CW'(1);
        ST_TRAIL: if (cnt == '0) begin
          state <= ST_IDLE; cs <= 1'b0; done <= 1'b1;
        end else cnt <= cnt - CW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: after an even number of transitions the clock is back at its rest level
  assert_sck_rest_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TRAIL) |-> (sck == cpol_q));
  // R11: once a frame is under way, the chip select holds until the trail ends
  assert_no_preempt_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |=> cs);
endmodule

// File: rtl/spi_dsi_arbiter.sv
module spi_dsi_arbiter
  import spi_arb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_ATTR = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 4,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  localparam int SZ_W = $clog2(DATA_W),
  localparam int AS_W = (NUM_ATTR > 1) ? $clog2(NUM_ATTR) : 1,
  localparam int ATTR_W = SZ_W + DIV_W + 2 + 2*DLY_W,
  localparam int CMD_W = AS_W + DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [1:0]               mode_sel,
  input  logic                     master_en,
  input  logic [NUM_ATTR*ATTR_W-1:0] attr_cfg,
  input  logic [AS_W-1:0]          dsi_attr_sel,
  input  logic                     tx_push,
  input  logic [CMD_W-1:0]         tx_cmd,
  output logic                     tx_full,
  input  logic                     rx_pop,
  output logic [DATA_W-1:0]        rx_data,
  output logic                     rx_empty,
  output logic                     rx_ovf,
  input  logic [DATA_W-1:0]        par_in,
  input  logic                     dsi_trig,
  output logic [DATA_W-1:0]        par_out,
  output logic                     sck,
  output logic                     sout,
  input  logic                     sin,
  output logic                     pcs_dsi_n,
  output logic                     pcs_spi_n
);
  logic              tx_empty, rx_full, busy, done, cs, is_dsi, dsi_pend;
  logic              active, dsi_req, start_spi, start_dsi, start, rx_wr;
  logic [CMD_W-1:0]  tx_head;
  logic [DATA_W-1:0] snap, rx_word, ld_data;
  logic [AS_W-1:0]   sel;
  logic [ATTR_W-1:0] entry;

  assign active    = (mode_sel == MODE_COMBINED) && master_en;
  assign dsi_req   = dsi_pend || (par_in != snap);
  assign start_spi = active && !busy && !tx_empty;
  assign start_dsi = active && !busy && tx_empty && dsi_req;
  assign start     = start_spi || start_dsi;
  assign sel       = start_spi ? tx_head[CMD_W-1:DATA_W] : dsi_attr_sel;
  assign ld_data   = start_spi ? tx_head[DATA_W-1:0] : par_in;
  assign rx_wr     = done && !is_dsi && !rx_full;

  always_comb begin
    entry = attr_cfg[ATTR_W-1:0];
    for (int i = 0; i < NUM_ATTR; i++)
      if (sel == AS_W'(i)) entry = attr_cfg[i*ATTR_W +: ATTR_W];
  end

  spi_arb_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .push(tx_push), .wdata(tx_cmd), .pop(start_spi),
    .rdata(tx_head), .full(tx_full), .empty(tx_empty));

  spi_arb_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .push(rx_wr), .wdata(rx_word), .pop(rx_pop),
    .rdata(rx_data), .full(rx_full), .empty(rx_empty));

  spi_arb_shifter #(.DW(DATA_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_shift (
    .clk(clk), .rst(rst), .start(start), .ld_data(ld_data),
    .size_m1(entry[SZ_W-1:0]),
    .div(entry[SZ_W +: DIV_W]),
    .cpol(entry[SZ_W+DIV_W]),
    .cpha(entry[SZ_W+DIV_W+1]),
    .pre_dly(entry[SZ_W+DIV_W+2 +: DLY_W]),
    .post_dly(entry[SZ_W+DIV_W+2+DLY_W +: DLY_W]),
    .sin(sin), .sck(sck), .sout(sout), .cs(cs), .busy(busy), .done(done),
    .rx_word(rx_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      is_dsi <= 1'b0; dsi_pend <= 1'b0; snap <= '0; par_out <= '0; rx_ovf <= 1'b0;
    end else begin
      if (start) is_dsi <= start_dsi;
      if (dsi_trig) dsi_pend <= 1'b1;
      else if (start_dsi) dsi_pend <= 1'b0;
      if (start_dsi) snap <= par_in;
      if (done && is_dsi) par_out <= rx_word;
      if (done && !is_dsi && rx_full) rx_ovf <= 1'b1;
    end
  end

  assign pcs_dsi_n = ~(cs & is_dsi);
  assign pcs_spi_n = ~(cs & ~is_dsi);

  assert_spi_first_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs) && is_dsi) |-> $past(tx_empty));
  assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!active && !busy) |=> !cs);
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    rx_ovf |=> rx_ovf);
  assert_parout_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !(done && is_dsi) |=> $stable(par_out));
endmodule

// File: tb/tb_spi_dsi_arbiter.sv
module tb_spi_dsi_arbiter;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst = 1'b1;
  logic [1:0] mode_sel = 2'b00;
  logic master_en = 1'b0;
  logic [71:0] attr_cfg;
  logic [1:0] dsi_attr_sel = 2'd2;
  logic tx_push = 1'b0, rx_pop = 1'b0, dsi_trig = 1'b0, inv = 1'b0;
  logic [17:0] tx_cmd = '0;
  logic [15:0] par_in = '0, rx_data, par_out;
  logic tx_full, rx_empty, rx_ovf, sck, sout, sin, pcs_dsi_n, pcs_spi_n;

  assign sin = sout ^ inv;

  spi_dsi_arbiter dut (.clk(clk), .rst(rst), .mode_sel(mode_sel), .master_en(master_en),
    .attr_cfg(attr_cfg), .dsi_attr_sel(dsi_attr_sel), .tx_push(tx_push), .tx_cmd(tx_cmd),
    .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty),
    .rx_ovf(rx_ovf), .par_in(par_in), .dsi_trig(dsi_trig), .par_out(par_out),
    .sck(sck), .sout(sout), .sin(sin), .pcs_dsi_n(pcs_dsi_n), .pcs_spi_n(pcs_spi_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  int a_m1[4]   = '{7, 15, 1, 11};
  int a_div[4]  = '{1, 0, 2, 0};
  int a_cpol[4] = '{0, 1, 0, 1};
  int a_cpha[4] = '{0, 1, 1, 0};
  int a_pre[4]  = '{1, 0, 2, 0};
  int a_post[4] = '{0, 2, 1, 0};

  int nchk = 0, nerr = 0, cyc = 0, nf = 0, both_low = 0;
  int f_typ[128], f_tog[128], f_lead[128], f_half[128], f_trail[128], f_sck0[128];
  logic [15:0] f_we[128], f_wo[128];

  function automatic int fbits(input int ai);
    return (a_m1[ai] < 3) ? 4 : a_m1[ai] + 1;
  endfunction
  function automatic logic [15:0] msk(input int n);
    return 16'((32'd1 << n) - 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // bus monitor: frame type, transitions, sampled bits and spacing
  logic in_fr = 1'b0, sck_prev = 1'b0;
  int tog, t_fall, t_first, t_second, t_last, typ, s0;
  logic [15:0] we, wo;
  always @(negedge clk) begin
    cyc++;
    if (!pcs_dsi_n && !pcs_spi_n) both_low++;
    if ((!pcs_dsi_n || !pcs_spi_n) && !in_fr) begin
      in_fr = 1'b1; typ = !pcs_dsi_n ? 1 : 0; t_fall = cyc; sck_prev = sck;
      s0 = int'(sck); tog = 0; we = '0; wo = '0; t_first = 0; t_second = 0; t_last = 0;
    end else if ((!pcs_dsi_n || !pcs_spi_n) && in_fr) begin
      if (sck != sck_prev) begin
        if (tog == 0) t_first = cyc;
        if (tog == 1) t_second = cyc;
        t_last = cyc;
        if (tog % 2 == 0) we = {we[14:0], sout}; else wo = {wo[14:0], sout};
        tog++;
        sck_prev = sck;
      end
    end else if (in_fr) begin
      in_fr = 1'b0;
      if (nf < 128) begin
        f_typ[nf] = typ; f_tog[nf] = tog; f_we[nf] = we; f_wo[nf] = wo; f_sck0[nf] = s0;
        f_lead[nf] = t_first - t_fall; f_half[nf] = t_second - t_first; f_trail[nf] = cyc - t_last;
      end
      nf++;
    end
  end

  task automatic push(input int sel, input logic [15:0] d);
    @(negedge clk); tx_push = 1'b1; tx_cmd = {2'(sel), d};
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [15:0] exp);
    @(negedge clk);
    chk(tag, rx_data, exp);
    rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic wait_frames(input int target);
    int t = 0;
    while (nf < target && t < 5000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    if (t >= 5000) begin nerr++; $display("FAIL R3: frame %0d never completed, expected it", target); end
  endtask

  task automatic chk_frame(input int k, input int ft, input int ai, input logic [15:0] d, input string ttag);
    int n = fbits(ai);
    chk(ttag, f_typ[k], ft);
    chk("R5 transition count from selected entry", f_tog[k], 2*n);
    chk("R6 R7 MSB-first bits on sout", a_cpha[ai] ? f_wo[k] : f_we[k], d & msk(n));
    chk("R6 sck rest level at select", f_sck0[k], a_cpol[ai]);
    chk("R12 lead spacing", f_lead[k], a_pre[ai] + a_div[ai] + 2);
    chk("R12 half period", f_half[k], a_div[ai] + 1);
    chk("R12 trail spacing", f_trail[k], a_post[ai] + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int k;
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++)
      attr_cfg[i*18 +: 18] = {4'(a_post[i]), 4'(a_pre[i]), 1'(a_cpha[i]), 1'(a_cpol[i]),
                              4'(a_div[i]), 4'(a_m1[i])};
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R4 reset pcs_dsi_n", pcs_dsi_n, 1);
    chk("R4 reset pcs_spi_n", pcs_spi_n, 1);
    chk("R10 reset rx_empty", rx_empty, 1);
    chk("R9 reset rx_ovf", rx_ovf, 0);
    chk("R8 reset par_out", par_out, 0);

    // R1: wrong mode, then master disabled
    mode_sel = 2'b01; master_en = 1'b1;
    push(1, 16'hA5C3); push(3, 16'h05F1);
    @(negedge clk); par_in = 16'h00B7; dsi_trig = 1'b1;
    @(negedge clk); dsi_trig = 1'b0;
    repeat (60) @(negedge clk);
    chk("R1 no frame in other mode", nf, 0);
    mode_sel = 2'b10; master_en = 1'b0;
    repeat (60) @(negedge clk);
    chk("R1 no frame with master off", nf, 0);
    chk("R1 commands stay queued", rx_empty, 1);

    // R2 R3: queued commands first, then the deserial frame
    master_en = 1'b1;
    wait_frames(3);
    chk_frame(0, 0, 1, 16'hA5C3, "R2 first frame is command");
    chk_frame(1, 0, 3, 16'h05F1, "R2 second frame is command");
    chk_frame(2, 1, 2, 16'h00B7, "R3 deserial frame after queue drains");
    pop_chk("R7 R10 first rx word", 16'hA5C3);
    pop_chk("R7 R10 second rx word", 16'h05F1);
    chk("R10 rx empty after pops", rx_empty, 1);
    chk("R8 par_out from deserial return", par_out, 16'h0007);

    // R11: command pushed mid-frame waits
    dsi_attr_sel = 2'd1; par_in = 16'h3C96;
    while (pcs_dsi_n) @(negedge clk);
    repeat (5) @(negedge clk);
    push(0, 16'h00E4);
    wait_frames(5);
    chk_frame(3, 1, 1, 16'h3C96, "R11 deserial frame type");
    chk_frame(4, 0, 0, 16'h00E4, "R11 command follows");
    chk("R8 par_out 16-bit return", par_out, 16'h3C96);
    pop_chk("R8 command return in rx FIFO", 16'h00E4);

    // R3: trigger pulse with unchanged inputs, inverted return
    inv = 1'b1;
    @(negedge clk); dsi_trig = 1'b1;
    @(negedge clk); dsi_trig = 1'b0;
    wait_frames(6);
    chk_frame(5, 1, 1, 16'h3C96, "R3 trigger starts deserial frame");
    chk("R8 par_out inverted return", par_out, 16'hC369);

    // R9 R10: fill, overflow, sticky flag
    mode_sel = 2'b00;
    for (int i = 1; i <= 5; i++) push(3, 16'(16'h0100 + i));
    chk("R10 tx_full after four pushes", tx_full, 1);
    mode_sel = 2'b10;
    wait_frames(10);
    chk("R9 no overflow yet", rx_ovf, 0);
    push(3, 16'h0106);
    wait_frames(11);
    repeat (50) @(negedge clk);
    chk("R10 push into full FIFO ignored", nf, 11);
    chk("R9 overflow flag set", rx_ovf, 1);
    chk("R8 par_out held over command frames", par_out, 16'hC369);
    for (int i = 1; i <= 4; i++) pop_chk("R9 R10 kept words in order", (~16'(16'h0100 + i)) & 16'h0FFF);
    chk("R9 dropped word absent", rx_empty, 1);
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
    @(negedge clk);
    chk("R10 pop on empty ignored", rx_empty, 1);
    chk("R9 overflow flag sticky", rx_ovf, 1);

    // random mix
    for (int it = 0; it < 24; it++) begin
      k = nf;
      if ($urandom % 2 == 0) begin
        int s = int'($urandom % 4);
        d = 16'($urandom);
        push(s, d);
        wait_frames(k + 1);
        chk_frame(k, 0, s, d, "R2 random command frame");
        pop_chk("R7 random rx word", (~d) & msk(fbits(s)));
      end else begin
        int s = int'($urandom % 4);
        @(negedge clk);
        dsi_attr_sel = 2'(s);
        par_in = par_in ^ (16'($urandom) | 16'h0001);
        wait_frames(k + 1);
        chk_frame(k, 1, s, par_in, "R3 random deserial frame");
        chk("R8 random par_out", par_out, (~par_in) & msk(fbits(s)));
      end
    end
    chk("R4 selects never low together", both_low, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule